// File: doc/BRIEF.md
# Dual Output Serial Read Engine

This block is the read path on the responding side of a serial flash-style link. The link clock, the active-low select and the single command line are sampled as ordinary inputs on a faster system clock, and edges of the link clock are found in that clock domain. A transaction starts with select going low. The block then takes in one command byte, a 24-bit start address and eight idle clocks. After that it returns bytes from a byte-wide memory, two bits per link clock. During that return phase both link data lines are used as outputs.

The memory is outside the block and has a synchronous read port. The block raises a one-cycle read strobe with a byte address, and the memory returns the byte on the next system clock. The block fetches the first byte as soon as the address is complete. It then fetches each following byte while the current one is being sent, so the memory latency never shows on the link. Each pin has its own data and enable output, and a low enable means that the pin is released to high impedance. Raising select at any time ends the transaction.

Top module: `dual_read_engine`

## Requirements
- R1: While `rst` is high, and on the clock after it is high, both pin enables and `mem_en` are low.
- R2: The command byte is taken MSB first from `si_in` on rising edges of `sclk`. The only command accepted is 0x3B. With any other value, no read strobe is issued and both pins stay released until select goes high.
- R3: The command is followed by 24 address bits, A23 first, and then 8 idle clocks. Both pins stay released for all 40 of these rising edges.
- R4: Pins change only after falling edges of `sclk`. The first two data bits are valid after the falling edge that follows the 40th rising edge, before the 41st rising edge.
- R5: Each byte takes four link clocks. `so_out` carries bits 7, 5, 3 and 1, and `si_out` carries bits 6, 4, 2 and 0, in that order.
- R6: The first byte comes from the start address. Each later byte comes from the previous address plus one, and 0xFFFFFF is followed by 0x000000.
- R7: Select high releases both pins and clears the command state within one system clock. The next select-low period is decoded from its first bit.
- R8: Each read strobe lasts one cycle. The first strobe carries the start address. An N-byte read issues exactly N+1 strobes, because the next byte is fetched ahead.
- R9: Link clock edges and `si_in` have no effect while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sclk` |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Link clock, sampled |
| cs_n | input | 1 | Link select, active low |
| si_in | input | 1 | Command line value, sampled |
| si_out | output | 1 | Even data bits driven on the command line |
| si_oe | output | 1 | Drive enable for the command line |
| so_out | output | 1 | Odd data bits driven on the response line |
| so_oe | output | 1 | Drive enable for the response line |
| mem_en | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, one clock after the strobe |

## Verification
The assertions check on every cycle that the pins are released during and after reset and while select is high. They also check that pin values change only after a detected falling link-clock edge, and that each read strobe is a single cycle. The interleaved bit split, the address order, the wrap from the top address, the handling of rejected commands and a clean restart after an aborted read can only be shown by the bench's transactions. These involve full byte values and address sequences across many link clocks.

// File: rtl/dre_pkg.sv
`timescale 1ns/1ps
package dre_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_e;
endpackage

// File: rtl/dre_edge.sv
`timescale 1ns/1ps
module dre_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q & ~cs_n;
  assign fall = ~sclk & sclk_q & ~cs_n;
endmodule

// File: rtl/dre_ctrl.sv
`timescale 1ns/1ps
module dre_ctrl
  import dre_pkg::*;
#(
  parameter int        ADDR_W     = 24,
  parameter int        CMD_W      = 8,
  parameter int        DUMMY_CLKS = 8,
  parameter logic [7:0] OPCODE    = 8'h3B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rise,
  input  logic              si_in,
  input  logic              next_req,
  output logic              data_phase,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int MAXLEN = (ADDR_W > DUMMY_CLKS) ? ADDR_W : DUMMY_CLKS;
  localparam int CNT_W  = $clog2(MAXLEN) + 1;

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [CMD_W-1:0]   op_sr;
  logic [CMD_W-1:0]   op_nxt;
  logic [ADDR_W-1:0]  addr_nxt;

  assign op_nxt     = {op_sr[CMD_W-2:0], si_in};
  assign addr_nxt   = {mem_addr[ADDR_W-2:0], si_in};
  assign data_phase = (phase == PH_DATA);

  always_ff @(posedge clk) begin
    mem_en <= 1'b0;
    if (rst || cs_n) begin
      phase <= PH_CMD;
      cnt   <= '0;
      op_sr <= '0;
      if (rst) mem_addr <= '0;
    end else begin
      if (rise) begin
        case (phase)
          PH_CMD: begin
            op_sr <= op_nxt;
            if (cnt == CNT_W'(CMD_W - 1)) begin
              cnt   <= '0;
              phase <= (op_nxt == OPCODE[CMD_W-1:0]) ? PH_ADDR : PH_IGNORE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            mem_addr <= addr_nxt;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt    <= '0;
              phase  <= PH_DUMMY;
              mem_en <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (phase == PH_DATA && next_req) begin
        mem_addr <= mem_addr + 1'b1;
        mem_en   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dre_ser.sv
`timescale 1ns/1ps
module dre_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              fall,
  input  logic              data_phase,
  input  logic              mem_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              next_req,
  output logic              so_out,
  output logic              so_oe,
  output logic              si_out,
  output logic              si_oe
);
  localparam int SLOTS  = DATA_W / 2;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              fetch_d;
  logic [DATA_W-1:0] pre_buf;
  logic [DATA_W-1:0] sr;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_d <= 1'b0;
      pre_buf <= '0;
    end else begin
      fetch_d <= mem_en;
      if (fetch_d) pre_buf <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    next_req <= 1'b0;
    if (rst || cs_n) begin
      so_oe <= 1'b0;
      si_oe <= 1'b0;
      slot  <= '0;
      sr    <= '0;
      if (rst) begin
        so_out <= 1'b0;
        si_out <= 1'b0;
      end
    end else if (data_phase && fall) begin
      so_oe <= 1'b1;
      si_oe <= 1'b1;
      slot  <= (slot == SLOT_W'(SLOTS - 1)) ? '0 : slot + 1'b1;
      if (slot == '0) begin
        so_out   <= pre_buf[DATA_W-1];
        si_out   <= pre_buf[DATA_W-2];
        sr       <= pre_buf << 2;
        next_req <= 1'b1;
      end else begin
        so_out <= sr[DATA_W-1];
        si_out <= sr[DATA_W-2];
        sr     <= sr << 2;
      end
    end
  end
endmodule

// File: rtl/dual_read_engine.sv
`timescale 1ns/1ps
module dual_read_engine #(
  parameter int         ADDR_W     = 24,
  parameter int         DATA_W     = 8,
  parameter int         DUMMY_CLKS = 8,
  parameter logic [7:0] OPCODE     = 8'h3B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              si_in,
  output logic              si_out,
  output logic              si_oe,
  output logic              so_out,
  output logic              so_oe,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic rise, fall, data_phase, next_req;

  dre_edge u_edge (
    .clk (clk), .rst (rst), .sclk (sclk), .cs_n (cs_n),
    .rise(rise), .fall(fall)
  );

  dre_ctrl #(
    .ADDR_W(ADDR_W), .CMD_W(8), .DUMMY_CLKS(DUMMY_CLKS), .OPCODE(OPCODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rise(rise), .si_in(si_in),
    .next_req(next_req), .data_phase(data_phase),
    .mem_en(mem_en), .mem_addr(mem_addr)
  );

  dre_ser #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fall(fall),
    .data_phase(data_phase), .mem_en(mem_en), .mem_rdata(mem_rdata),
    .next_req(next_req), .so_out(so_out), .so_oe(so_oe),
    .si_out(si_out), .si_oe(si_oe)
  );
endmodule

// File: rtl/dre_checker.sv
`timescale 1ns/1ps
module dre_checker (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic cs_n,
  input logic so_out,
  input logic so_oe,
  input logic si_out,
  input logic si_oe,
  input logic mem_en
);
  logic sclk_d, fall_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      fall_d <= 1'b0;
    end else begin
      sclk_d <= sclk;
      fall_d <= !sclk && sclk_d && !cs_n;
    end
  end

  p_reset_release_r1: assert property (@(posedge clk)
    rst |=> (!so_oe && !si_oe && !mem_en));

  p_change_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (so_oe && $past(so_oe) && !fall_d) |-> ($stable(so_out) && $stable(si_out)));

  p_deselect_release_r7: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!so_oe && !si_oe && !mem_en));

  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> (!mem_en && !so_oe && !si_oe));
endmodule

bind dual_read_engine dre_checker u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n),
  .so_out(so_out), .so_oe(so_oe), .si_out(si_out), .si_oe(si_oe),
  .mem_en(mem_en)
);

// File: tb/tb_dual_read_engine.sv
`timescale 1ns/1ps
module tb_dual_read_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        si_in = 1'b0;
  logic        si_out, si_oe, so_out, so_oe, mem_en;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int failures = 0;
  int req_cnt = 0;
  logic [23:0] first_addr = '0;
  logic req_clr = 1'b0;
  logic hz_bad;

  always #2.5 clk = ~clk;

  dual_read_engine dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si_in(si_in),
    .si_out(si_out), .si_oe(si_oe), .so_out(so_out), .so_oe(so_oe),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_fn(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_en) mem_rdata <= mem_fn(mem_addr);
    if (req_clr) req_cnt = 0;
    else if (mem_en) begin
      if (req_cnt == 0) first_addr = mem_addr;
      req_cnt = req_cnt + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_reqs();
    req_clr = 1'b1; tick(1); req_clr = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    si_in = b;
    tick(4);
    if (so_oe || si_oe) hz_bad = 1'b1;
    sclk = 1'b1;
    tick(4);
    sclk = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] a);
    hz_bad = 1'b0;
    cs_n = 1'b0;
    tick(2);
    for (int i = 7; i >= 0; i--) send_bit(op[i]);
    for (int i = 23; i >= 0; i--) send_bit(a[i]);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
  endtask

  task automatic read_byte(output logic [7:0] b, output logic oe_ok);
    oe_ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(4);
      b[7-2*k] = so_out;
      b[6-2*k] = si_out;
      if (!so_oe || !si_oe) oe_ok = 1'b0;
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
  endtask

  task automatic end_cmd();
    cs_n = 1'b1;
    tick(2);
    check(!so_oe && !si_oe, "R7 release on deselect", {so_oe, si_oe}, 0);
  endtask

  task automatic do_read(input logic [23:0] a, input int n);
    logic [7:0] b;
    logic ok;
    clear_reqs();
    send_cmd(8'h3B, a);
    check(!hz_bad, "R3 pins released in command phases", hz_bad, 0);
    for (int j = 0; j < n; j++) begin
      read_byte(b, ok);
      // R4/R5: bits sampled before each rising edge, interleaved split
      check(ok && b == mem_fn(a + 24'(j)), "R4/R5/R6 data byte", b, mem_fn(a + 24'(j)));
    end
    check(first_addr == a, "R8 first strobe address", first_addr, a);
    end_cmd();
    check(req_cnt == n + 1, "R8 strobe count", req_cnt, n + 1);
  endtask

  localparam logic [31:0] VEC [0:5] = '{
    {24'h000000, 8'd3},
    {24'h123456, 8'd4},
    {24'h0000FF, 8'd3},
    {24'h00FFFE, 8'd3},
    {24'h7FFFFF, 8'd2},
    {24'hABCDEF, 8'd5}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic ok;
    tick(4);
    check(!so_oe && !si_oe && !mem_en, "R1 reset state", {so_oe, si_oe, mem_en}, 0);
    rst = 1'b0;
    tick(2);
    check(!so_oe && !si_oe && !mem_en, "R1 after reset", {so_oe, si_oe, mem_en}, 0);

    for (int v = 0; v < 6; v++) do_read(VEC[v][31:8], int'(VEC[v][7:0]));

    // R6: wrap from the top address
    do_read(24'hFFFFFF, 3);

    // R2: rejected command, then one bit off the accepted value
    for (int t = 0; t < 2; t++) begin
      clear_reqs();
      send_cmd(t == 0 ? 8'h0B : 8'h3A, 24'h000010);
      for (int k = 0; k < 8; k++) send_bit(1'b1);
      check(!hz_bad, "R2 pins released after rejected command", hz_bad, 0);
      check(req_cnt == 0, "R2 no strobe after rejected command", req_cnt, 0);
      end_cmd();
    end
    do_read(24'h000010, 1);

    // R7: abort in the middle of a byte, then restart
    send_cmd(8'h3B, 24'h00FF00);
    read_byte(b, ok);
    for (int k = 0; k < 2; k++) begin
      tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
    end
    end_cmd();
    do_read(24'h345678, 2);

    // R9: link activity while deselected
    clear_reqs();
    for (int k = 0; k < 20; k++) begin
      si_in = k[0];
      tick(2); sclk = 1'b1; tick(2); sclk = 1'b0;
    end
    check(req_cnt == 0 && !so_oe && !si_oe, "R9 idle while deselected", req_cnt, 0);
    do_read(24'h0A0B0C, 2);

    // R1: reset in the middle of the data phase
    send_cmd(8'h3B, 24'h000100);
    read_byte(b, ok);
    rst = 1'b1;
    tick(2);
    check(!so_oe && !si_oe && !mem_en, "R1 reset mid-read", {so_oe, si_oe, mem_en}, 0);
    cs_n = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(2);
    do_read(24'h000100, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule